// File: doc/BRIEF.md
# Two-Tone Cassette Tape Modulator

This block turns a byte into a frequency-shift-keyed tone burst for recording on audio tape. When a load strobe is seen while the block is idle, it captures the byte and two 3-bit tone selects. It then sends an eleven-bit frame on a single serial output: one start bit, the eight data bits with the least significant bit first, and two stop bits. Each bit is not sent as a level. It is sent as a square-wave tone: a zero uses the tone picked by the zero-tone select, and a one uses the tone picked by the one-tone select.

Each tone select picks a division of the basic clock. The code selects 1/64 for code 0 and doubles the division up to 1/1024 for code 4. Codes 5 to 7 are reserved and act as 1/1024. Every bit period lasts sixteen cycles of the slower of the two chosen tones, so both tones fit a whole number of cycles into every bit. A busy flag covers the frame plus one trailing cycle. The output rests low whenever no frame is being sent. All divisions, the period multiplier and the frame shape are parameters. The defaults give the values above.

Top module: `tape_fsk_tx`

## Requirements
- R1: Frame bits go out in this order: a start bit of value 0, then data bits 0 through 7, then two stop bits of value 1.
- R2: A bit of value 0 is sent with the zero-tone select, and a bit of value 1 with the one-tone select.
- R3: A tone select code c from 0 to 4 gives a square wave with a period of 2^(6+c) basic-clock cycles and 50% duty. The wave restarts high at the first cycle of every bit.
- R4: Tone select codes 5, 6 and 7 behave exactly like code 4 (1/1024).
- R5: Every bit lasts 16 times the larger of the two selected tone periods, counted in basic-clock cycles.
- R6: After reset, and whenever the block is idle, busy is 0 and the serial output is 0.
- R7: A load strobe seen while idle is accepted at that clock edge. In the next cycle busy is 1 and the first cycle of the start bit is on the output.
- R8: A load strobe while busy is ignored. The running frame, including its data and tone selects, goes on unchanged.
- R9: After the last stop bit ends, busy stays 1 for exactly one more cycle with the output low, then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that starts a frame when idle |
| data_in | input | 8 | Byte to send |
| sel_zero | input | 3 | Tone code for 0 bits |
| sel_one | input | 3 | Tone code for 1 bits |
| busy | output | 1 | Frame in progress, including the trailing cycle |
| sdo | output | 1 | Modulated serial output |

## Verification
A wrong tick counter or a wrong period-end detector shows up within one bit period. The output square wave would drift out of phase with the tone computed at the bench, or the next bit would start one or more cycles early or late. A corrupted shift register or bit index gives the wrong tone at the first affected bit. A wrong end of frame gives a wrong busy value at the trailing cycle. The bench compares both outputs on every cycle of every frame, for all 64 pairs of tone codes, so any such fault is reported in the cycle where it first reaches a port.

// File: rtl/tape_fsk_pkg.sv
package tape_fsk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_TAIL = 2'd2
   } tx_state_t;
endpackage

// File: rtl/tape_fsk_tone_sel.sv
module tape_fsk_tone_sel #(
   parameter int SEL_W    = 3,
   parameter int BASE_LOG = 6,
   parameter int MAX_CODE = 4,
   parameter int SH_W     = 4
) (
   input  logic [SEL_W-1:0] code,
   output logic [SH_W-1:0]  shift
);
   localparam int FULL_CODES = 1 << SEL_W;

   generate
      if (MAX_CODE >= FULL_CODES - 1) begin : g_direct
         always_comb shift = SH_W'(BASE_LOG) + SH_W'(code);
      end else begin : g_clamp
         always_comb begin
            if (int'(code) > MAX_CODE)
               shift = SH_W'(BASE_LOG + MAX_CODE);
            else
               shift = SH_W'(BASE_LOG) + SH_W'(code);
         end
      end
   endgenerate
endmodule

// File: rtl/tape_fsk_frame.sv
module tape_fsk_frame #(
   parameter int DATA_W    = 8,
   parameter int STOP_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   input  logic              advance,
   output logic              cur_bit,
   output logic              last_bit
);
   localparam int FRAME_BITS = 1 + DATA_W + STOP_BITS;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] shreg_q;
   logic [IDX_W-1:0]      idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         idx_q   <= '0;
      end else if (start) begin
         shreg_q <= {{STOP_BITS{1'b1}}, data, 1'b0};
         idx_q   <= '0;
      end else if (advance) begin
         shreg_q <= {1'b0, shreg_q[FRAME_BITS-1:1]};
         idx_q   <= idx_q + 1'b1;
      end
   end

   assign cur_bit  = shreg_q[0];
   assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));
endmodule

// File: rtl/tape_fsk_tx.sv
module tape_fsk_tx #(
   parameter int DATA_W     = 8,
   parameter int STOP_BITS  = 2,
   parameter int SEL_W      = 3,
   parameter int BASE_LOG   = 6,
   parameter int MAX_CODE   = 4,
   parameter int PERIOD_LOG = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data_in,
   input  logic [SEL_W-1:0]  sel_zero,
   input  logic [SEL_W-1:0]  sel_one,
   output logic              busy,
   output logic              sdo
);
   import tape_fsk_pkg::*;

   localparam int MAX_SHIFT = BASE_LOG + MAX_CODE;
   localparam int TICK_W    = PERIOD_LOG + MAX_SHIFT;
   localparam int SH_W      = $clog2(TICK_W);

   generate
      if (BASE_LOG < 1)       begin : g_bad_base   $error("BASE_LOG must be at least 1"); end
      if (PERIOD_LOG < 1)     begin : g_bad_period $error("PERIOD_LOG must be at least 1"); end
      if (MAX_CODE < 0)       begin : g_bad_code   $error("MAX_CODE must not be negative"); end
      if (MAX_CODE >= (1 << SEL_W)) begin : g_bad_sel $error("SEL_W too narrow for MAX_CODE"); end
   endgenerate

   tx_state_t         state_q;
   logic [TICK_W-1:0] tick_q;
   logic [SH_W-1:0]   shx_q, shy_q;
   logic [SH_W-1:0]   shx_d, shy_d;
   logic [SH_W-1:0]   cur_sh, slow_sh;
   logic [SH_W:0]     span_sh;
   logic [TICK_W-1:0] span_mask;
   logic              bit_end;
   logic              cur_bit, last_bit;
   logic              accept, advance;

   tape_fsk_tone_sel #(.SEL_W(SEL_W), .BASE_LOG(BASE_LOG), .MAX_CODE(MAX_CODE), .SH_W(SH_W))
      zero_sel_i (.code(sel_zero), .shift(shx_d));
   tape_fsk_tone_sel #(.SEL_W(SEL_W), .BASE_LOG(BASE_LOG), .MAX_CODE(MAX_CODE), .SH_W(SH_W))
      one_sel_i  (.code(sel_one),  .shift(shy_d));

   assign accept  = (state_q == ST_IDLE) && load;
   assign advance = (state_q == ST_SEND) && bit_end && !last_bit;

   tape_fsk_frame #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) frame_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .data     (data_in),
      .advance  (advance),
      .cur_bit  (cur_bit),
      .last_bit (last_bit)
   );

   always_comb begin
      slow_sh = (shx_q > shy_q) ? shx_q : shy_q;
      span_sh = (SH_W+1)'(PERIOD_LOG) + {1'b0, slow_sh};
      for (int i = 0; i < TICK_W; i++)
         span_mask[i] = (32'(i) < 32'(span_sh));
      bit_end = ~|(~tick_q & span_mask);
      cur_sh  = cur_bit ? shy_q : shx_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tick_q  <= '0;
         shx_q   <= SH_W'(BASE_LOG);
         shy_q   <= SH_W'(BASE_LOG);
      end else begin
         case (state_q)
            ST_IDLE: if (load) begin
               state_q <= ST_SEND;
               tick_q  <= '0;
               shx_q   <= shx_d;
               shy_q   <= shy_d;
            end
            ST_SEND: begin
               if (bit_end) begin
                  tick_q <= '0;
                  if (last_bit) state_q <= ST_TAIL;
               end else begin
                  tick_q <= tick_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign sdo  = (state_q == ST_SEND) && !tick_q[cur_sh - 1'b1];
endmodule

// File: rtl/tape_fsk_tx_chk.sv
module tape_fsk_tx_chk #(
   parameter int TICK_W    = 14,
   parameter int SH_W      = 4,
   parameter int BASE_LOG  = 6,
   parameter int MAX_SHIFT = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load,
   input logic              busy,
   input logic              sdo,
   input logic [1:0]        state,
   input logic [SH_W-1:0]   shx,
   input logic [SH_W-1:0]   shy,
   input logic              bit_end,
   input logic [TICK_W-1:0] tick
);
   p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sdo);

   p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && load) |=> (busy && sdo));

   p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(shx) && $stable(shy)));

   p_tail_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) |-> (busy && !sdo) ##1 !busy);

   p_shift_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(shx) >= BASE_LOG) && (32'(shx) <= MAX_SHIFT) &&
      (32'(shy) >= BASE_LOG) && (32'(shy) <= MAX_SHIFT));

   p_tick_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1 && bit_end) |=> (tick == '0));
endmodule

bind tape_fsk_tx tape_fsk_tx_chk #(
   .TICK_W(TICK_W), .SH_W(SH_W), .BASE_LOG(BASE_LOG), .MAX_SHIFT(MAX_SHIFT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .sdo(sdo),
   .state(state_q), .shx(shx_q), .shy(shy_q), .bit_end(bit_end), .tick(tick_q)
);

// File: tb/tape_fsk_tx_tb_top.sv
module tape_fsk_tx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BL   = 1;
   localparam int MC   = 4;
   localparam int PL   = 2;
   localparam int WDOG = 190000;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       load = 0;
   logic [7:0] data_in = 0;
   logic [2:0] sel_zero = 0, sel_one = 0;
   logic       busy, sdo;
   int         errors = 0, checks = 0, cycles = 0;
   bit         done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tape_fsk_tx #(.BASE_LOG(BL), .MAX_CODE(MC), .PERIOD_LOG(PL)) dut_i (
      .clk(clk), .rst_n(rst_n), .load(load), .data_in(data_in),
      .sel_zero(sel_zero), .sel_one(sel_one), .busy(busy), .sdo(sdo));

   function automatic int shift_of(int code);
      return BL + ((code > MC) ? MC : code); // R3 and R4
   endfunction

   task automatic check(string tag, logic b, logic s, logic eb, logic es);
      checks++;
      if (b !== eb || s !== es) begin
         errors++;
         $display("FAIL %s: busy=%b sdo=%b expected busy=%b sdo=%b", tag, b, s, eb, es);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG && !done) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected at most %0d", cycles, WDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic run_frame(int cx, int cy, logic [7:0] d);
      int sx = shift_of(cx);
      int sy = shift_of(cy);
      int p  = 1 << (PL + ((sx > sy) ? sx : sy)); // R5
      int fb = 11 * p;
      @(posedge clk); #1;
      data_in = d; sel_zero = 3'(cx); sel_one = 3'(cy); load = 1;
      @(posedge clk); #1;   // R7: accepted here
      load = 0;
      for (int n = 0; n <= fb + 1; n++) begin
         @(negedge clk);
         if (n < fb) begin
            int b = n / p;
            int t = n % p;
            // R1 frame order: start 0, data LSB first, two stop 1
            logic bv = (b == 0) ? 1'b0 : (b <= 8) ? d[b-1] : 1'b1;
            int   s  = bv ? sy : sx; // R2
            logic es = (((t >> (s - 1)) & 1) == 0);
            int   c  = bv ? cy : cx;
            check((n == 0) ? "R7" : (c > MC) ? "R4" : "R3", busy, sdo, 1'b1, es);
         end else if (n == fb) begin
            check("R9", busy, sdo, 1'b1, 1'b0);
         end else begin
            check("R9", busy, sdo, 1'b0, 1'b0);
         end
         if (n == 3) begin
            // R8: strobe while busy with other data and codes
            data_in = ~d; sel_zero = 3'(cy); sel_one = 3'(cx ^ 1); load = 1;
         end else begin
            load = 0;
         end
      end
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         check("R6", busy, sdo, 1'b0, 1'b0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 2 + 1);
      check("R6", busy, sdo, 1'b0, 1'b0);
      rst_n = 1;
      @(negedge clk);
      check("R6", busy, sdo, 1'b0, 1'b0);
      for (int cx = 0; cx < 8; cx++)
         for (int cy = 0; cy < 8; cy++)
            run_frame(cx, cy, 8'((cx * 37 + cy * 11) ^ 8'hA5));
      run_frame(0, 0, 8'h00);
      run_frame(1, 2, 8'hFF);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule